// File: doc/BRIEF.md
# I/Q Serial Receive Word Serializer

This block turns parallel I and Q sample pairs into a single-line serial stream for a downstream receiver such as the serial port of a signal processor. It generates its own receive clock by dividing the system clock, drives one data line and one frame-sync line, and sends every pair as two 16-bit words, I before Q. Each word carries a 15-bit payload, most significant bit first, and ends in a flag bit that tells the receiver which half of the pair it is reading.

Data and frame sync change only where the receive clock rises, so they are stable when the receiver samples them on the falling edge. A pair is offered with a one-cycle valid strobe. One pair can wait in a holding register while the previous pair is still being shifted, so a source that produces pairs at the line rate keeps the line busy without gaps. A pair offered when the holding register is already taken is thrown away, and a sticky overrun flag records that loss.

Top module: `iq_serial_tx`

## Requirements
- R1: After reset, rx_clk, rx_data, rx_frame and overrun are all 0.
- R2: rx_clk has a period of 2*HALF_BIT system clocks and is high for the first HALF_BIT clocks of each bit period and low for the other HALF_BIT; rx_data and rx_frame change only on the system clock edge at which rx_clk rises.
- R3: Each pair goes out as 32 consecutive bit periods: the I word, then the Q word; each word is the 15-bit payload, most significant bit first, followed by one flag bit.
- R4: The flag bit (bit period 16 and bit period 32 of a pair) is 0 in the I word and 1 in the Q word.
- R5: rx_frame is 1 for exactly the first bit period of each word (bit periods 1 and 17 of a pair) and 0 in every other bit period.
- R6: In a bit period in which no pair is being sent, rx_data and rx_frame are both 0.
- R7: A pair offered while another pair is being shifted is held and its first bit follows the previous Q flag bit with no idle bit between them; a pair offered on the very clock edge at which the held pair moves into the shifter is also accepted.
- R8: A pair offered while the holding register is occupied and not being emptied on that edge is discarded and never sent; overrun becomes 1 on the next cycle and stays 1 until reset.
- R9: A pair offered while nothing is pending starts at the next bit-period boundary: its first bit appears on the outputs 1 to 2*HALF_BIT system clocks after the edge that samples in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One-cycle strobe offering a sample pair |
| in_i | input | SAMPLE_W | I payload of the offered pair |
| in_q | input | SAMPLE_W | Q payload of the offered pair |
| rx_clk | output | 1 | Generated receive clock |
| rx_data | output | 1 | Serial word data |
| rx_frame | output | 1 | Word start marker, one bit period wide |
| overrun | output | 1 | Sticky flag: a pair was discarded |

## Verification
The hardest situation to reach from the ports is a new pair arriving on the exact system clock edge at which the held pair moves into the shifter, since only that edge separates acceptance from loss. The bench fills the shifter and the holding register, waits until the serial monitor has captured the second-to-last bit of the first pair, and then offers a third pair at a swept offset of a few system clocks around the predicted boundary. Each offset runs from a fresh reset, and the bench works out from the bit timing whether the third pair must appear on the line or must set overrun and vanish.

// File: rtl/iqs_pkg.sv
package iqs_pkg;
  // Value carried by the flag bit at the end of each serial word.
  typedef enum logic {
    LANE_I = 1'b0,
    LANE_Q = 1'b1
  } lane_e;
endpackage

// File: rtl/iqs_bit_clock.sv
module iqs_bit_clock #(
  parameter int HALF_BIT = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic rxclk_q
);
  localparam int PERIOD = 2 * HALF_BIT;
  localparam int PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD - 1);
  localparam logic [PW-1:0] PH_FALL = PW'(HALF_BIT - 1);

  logic [PW-1:0] phase;

  // The edge after PH_LAST starts a new bit period.
  assign tick = (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      rxclk_q <= 1'b0;
    end else if (tick) begin
      phase   <= '0;
      rxclk_q <= 1'b1;
    end else begin
      phase <= phase + PW'(1);
      if (phase == PH_FALL) rxclk_q <= 1'b0;
    end
  end

  // R2: the receive clock rises at every bit boundary
  assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> rxclk_q);
  // R2: the receive clock never rises away from a bit boundary
  assert_no_stray_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !rxclk_q) |=> !rxclk_q);
endmodule

// File: rtl/iqs_pair_slot.sv
module iqs_pair_slot #(
  parameter int SAMPLE_W = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  input  logic                take,
  output logic                full,
  output logic [SAMPLE_W-1:0] slot_i,
  output logic [SAMPLE_W-1:0] slot_q,
  output logic                overrun
);
  logic accept;
  logic drop;

  // A slot being emptied on this edge may be refilled on the same edge.
  assign accept = in_valid && (!full || take);
  assign drop   = in_valid && full && !take;

  always_ff @(posedge clk) begin
    if (rst) begin
      full    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (accept)    full <= 1'b1;
      else if (take) full <= 1'b0;
      if (drop) overrun <= 1'b1;
    end
  end

  // Payload registers carry no reset: they are only read while full is set.
  always_ff @(posedge clk) begin
    if (accept) begin
      slot_i <= in_i;
      slot_q <= in_q;
    end
  end

  // R8: a loss is remembered until reset
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  // R8: a pair offered into an occupied slot raises the flag
  assert_drop_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && full && !take) |=> overrun);
  // R8: the held pair survives a dropped offer
  assert_keep_on_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && full && !take) |=> (full && $stable(slot_i) && $stable(slot_q)));
  // R7: the shifter only unloads a filled slot
  assert_take_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    take |-> full);
endmodule

// File: rtl/iqs_shifter.sv
module iqs_shifter
  import iqs_pkg::*;
#(
  parameter int SAMPLE_W = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                have,
  input  logic [SAMPLE_W-1:0] pair_i,
  input  logic [SAMPLE_W-1:0] pair_q,
  output logic                take,
  output logic                data_q,
  output logic                frame_q
);
  localparam int WORD_W = SAMPLE_W + 1;
  localparam int PAIR_W = 2 * WORD_W;
  localparam int CW     = $clog2(PAIR_W + 1);
  localparam logic [CW-1:0] LEFT_FULL = CW'(PAIR_W - 1);
  localparam logic [CW-1:0] LEFT_QSTART = CW'(WORD_W);
  localparam logic [CW-1:0] LEFT_IFLAG = CW'(WORD_W + 1);
  localparam logic [CW-1:0] LEFT_QFLAG = CW'(1);

  logic [PAIR_W-1:0] pair_word;
  logic [PAIR_W-1:0] sr;
  logic [CW-1:0]     left;

  assign pair_word = {pair_i, LANE_I, pair_q, LANE_Q};
  assign take      = tick && (left == '0) && have;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      left    <= '0;
      data_q  <= 1'b0;
      frame_q <= 1'b0;
    end else if (tick) begin
      if (left == '0) begin
        if (have) begin
          data_q  <= pair_word[PAIR_W-1];
          sr      <= {pair_word[PAIR_W-2:0], 1'b0};
          left    <= LEFT_FULL;
          frame_q <= 1'b1;
        end else begin
          data_q  <= 1'b0;
          frame_q <= 1'b0;
        end
      end else begin
        data_q  <= sr[PAIR_W-1];
        sr      <= {sr[PAIR_W-2:0], 1'b0};
        left    <= left - CW'(1);
        frame_q <= (left == LEFT_QSTART);
      end
    end
  end

  // R2: outputs move only at bit boundaries
  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(data_q) && $stable(frame_q)));
  // R5: the frame marker lasts one bit period
  assert_frame_one_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (frame_q && tick) |=> !frame_q);
  // R4: the I word ends in a 0 flag
  assert_i_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && left == LEFT_IFLAG) |=> (data_q == LANE_I));
  // R4: the Q word ends in a 1 flag
  assert_q_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && left == LEFT_QFLAG) |=> (data_q == LANE_Q));
  // R6: the line idles low when nothing is waiting
  assert_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && left == '0 && !have) |=> (!data_q && !frame_q));
endmodule

// File: rtl/iq_serial_tx.sv
module iq_serial_tx #(
  parameter int SAMPLE_W = 15,
  parameter int HALF_BIT = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  output logic                rx_clk,
  output logic                rx_data,
  output logic                rx_frame,
  output logic                overrun
);
  logic                tick;
  logic                take;
  logic                full;
  logic [SAMPLE_W-1:0] slot_i;
  logic [SAMPLE_W-1:0] slot_q;

  iqs_bit_clock #(.HALF_BIT(HALF_BIT)) u_clock (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .rxclk_q (rx_clk)
  );

  iqs_pair_slot #(.SAMPLE_W(SAMPLE_W)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_i     (in_i),
    .in_q     (in_q),
    .take     (take),
    .full     (full),
    .slot_i   (slot_i),
    .slot_q   (slot_q),
    .overrun  (overrun)
  );

  iqs_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .have    (full),
    .pair_i  (slot_i),
    .pair_q  (slot_q),
    .take    (take),
    .data_q  (rx_data),
    .frame_q (rx_frame)
  );

  // R2: data never moves while the receive clock is low
  assert_data_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (!rx_clk && !$rose(rx_clk)) |=> ($stable(rx_data) || rx_clk));
endmodule

// File: tb/iq_serial_tx_test.sv
module iq_serial_tx_test;
  localparam int SW   = 15;
  localparam int HALF = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_i = '0;
  logic [SW-1:0] in_q = '0;
  logic          rx_clk, rx_data, rx_frame, overrun;

  iq_serial_tx #(.SAMPLE_W(SW), .HALF_BIT(HALF)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .rx_clk(rx_clk), .rx_data(rx_data), .rx_frame(rx_frame), .overrun(overrun)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Serial monitor state
  logic          prev_rx, prev_data, prev_frame;
  int            hi_run, lo_run;
  bit            seen_rise, in_word;
  int            wbits, bits_seen, words_rx, gap_bits;
  logic [15:0]   wreg;
  logic [SW-1:0] exp_pay[$];
  logic          exp_flag[$];

  always @(negedge clk) begin : monitor
    logic [SW-1:0] ep;
    logic          ef;
    if (rst) begin
      prev_rx = 0; prev_data = 0; prev_frame = 0;
      hi_run = 0; lo_run = 0; seen_rise = 0; in_word = 0;
      wbits = 0; bits_seen = 0; words_rx = 0; gap_bits = 0; wreg = '0;
    end else begin
      if (rx_data !== prev_data || rx_frame !== prev_frame)
        chk(rx_clk && !prev_rx, "R2 output moved away from rx_clk rise", rx_clk, 1);
      if (rx_clk && !prev_rx) begin
        if (seen_rise) chk(lo_run == HALF, "R2 rx_clk low time", lo_run, HALF);
        seen_rise = 1; hi_run = 1;
      end else if (!rx_clk && prev_rx) begin
        chk(hi_run == HALF, "R2 rx_clk high time", hi_run, HALF);
        lo_run = 1;
        // receiver samples here, on the falling edge
        if (rx_frame) begin
          chk(!in_word, "R5 frame inside a word", wbits, 16);
          in_word = 1; wbits = 1; wreg = {15'b0, rx_data}; bits_seen++;
        end else if (in_word) begin
          wbits++; wreg = {wreg[14:0], rx_data}; bits_seen++;
        end else begin
          chk(!rx_data, "R6 idle data low", rx_data, 0);
          gap_bits++;
        end
        if (in_word && wbits == 16) begin
          in_word = 0;
          words_rx++;
          if (exp_pay.size() == 0) chk(0, "R8 unexpected word", wreg, 0);
          else begin
            ep = exp_pay.pop_front();
            ef = exp_flag.pop_front();
            chk(wreg[15:1] == ep, "R3 payload", wreg[15:1], ep);
            chk(wreg[0] == ef, "R4 flag bit", wreg[0], ef);
          end
        end
      end else if (rx_clk) hi_run++;
      else lo_run++;
      prev_rx = rx_clk; prev_data = rx_data; prev_frame = rx_frame;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    exp_pay.delete(); exp_flag.delete();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!rx_clk && !rx_data && !rx_frame && !overrun, "R1 reset state",
        {rx_clk, rx_data, rx_frame, overrun}, 0);
  endtask

  task automatic expect_pair(input logic [SW-1:0] i, input logic [SW-1:0] q);
    exp_pay.push_back(i); exp_flag.push_back(1'b0);
    exp_pay.push_back(q); exp_flag.push_back(1'b1);
  endtask

  task automatic send(input logic [SW-1:0] i, input logic [SW-1:0] q);
    @(negedge clk);
    in_valid = 1; in_i = i; in_q = q;
    @(negedge clk);
    in_valid = 0;
  endtask

  // Offer a pair to an idle block and measure the start latency (R9).
  task automatic send_idle(input logic [SW-1:0] i, input logic [SW-1:0] q);
    int c;
    expect_pair(i, q);
    @(negedge clk);
    in_valid = 1; in_i = i; in_q = q;
    c = 0;
    while (c < 100) begin
      @(negedge clk);
      c++;
      if (c == 1) in_valid = 0;
      if (rx_frame) break;
    end
    chk(c >= 2 && c <= 2 * HALF + 1, "R9 start latency", c, 2 * HALF + 1);
  endtask

  task automatic wait_words(input int n);
    while (words_rx < n) @(posedge clk);
  endtask

  task automatic wait_bits(input int n);
    while (bits_seen < n) @(posedge clk);
  endtask

  task automatic idle_bits(input int n);
    repeat (n * 2 * HALF) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin : main
    int g;
    logic [SW-1:0] vi, vq;
    do_reset();

    // R3 R4 R9: single pairs from idle, walking ones and arithmetic patterns
    for (int n = 0; n < SW; n++) begin
      vi = SW'(1) << n;
      vq = SW'((n * 1234 + 77) % 32768);
      send_idle(vi, vq);
      wait_words(words_rx + 2);
      idle_bits(2);
    end
    send_idle('0, '1);
    wait_words(words_rx + 2);
    send_idle('1, '0);
    wait_words(words_rx + 2);
    g = gap_bits;
    idle_bits(4);
    chk(gap_bits >= g + 3, "R6 idle bit periods observed", gap_bits - g, 3);
    chk(exp_pay.size() == 0, "R3 all words delivered", exp_pay.size(), 0);

    // R7: back-to-back pairs through the holding register
    do_reset();
    send_idle(15'h1357, 15'h2468);
    g = gap_bits;
    expect_pair(15'h7001, 15'h0ffe);
    send(15'h7001, 15'h0ffe);
    wait_bits(33);
    expect_pair(15'h5555, 15'h2aaa);
    send(15'h5555, 15'h2aaa);
    wait_words(6);
    chk(gap_bits == g, "R7 no idle bit between held pairs", gap_bits - g, 0);
    chk(!overrun, "R7 no overrun on held pairs", overrun, 0);
    chk(exp_pay.size() == 0, "R7 all held words delivered", exp_pay.size(), 0);

    // R7 R8: third pair swept around the edge at which the slot empties
    for (int k = 3 * HALF - 3; k <= 3 * HALF; k++) begin
      bit acc;
      acc = (k >= 3 * HALF - 1);
      do_reset();
      send_idle(15'h0a0a, 15'h0505);
      expect_pair(15'h3c3c, 15'h43c3);
      send(15'h3c3c, 15'h43c3);
      wait_bits(31);
      repeat (k) @(negedge clk);
      in_valid = 1; in_i = 15'h6161; in_q = 15'h1e1e;
      if (acc) expect_pair(15'h6161, 15'h1e1e);
      @(negedge clk);
      in_valid = 0;
      wait_words(acc ? 6 : 4);
      idle_bits(6);
      if (acc) chk(!overrun, "R7 same-edge offer accepted", overrun, 0);
      else     chk(overrun, "R8 offer into full slot flags overrun", overrun, 1);
      chk(words_rx == (acc ? 6 : 4), "R8 dropped pair never sent", words_rx, acc ? 6 : 4);
      chk(exp_pay.size() == 0, "R7 expected words delivered", exp_pay.size(), 0);
      if (!acc) begin
        idle_bits(4);
        chk(overrun, "R8 overrun stays set", overrun, 1);
      end
    end

    // R1 R8: reset clears the sticky flag
    do_reset();
    chk(!overrun, "R8 overrun cleared by reset", overrun, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule